// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This controller gathers a bank of peripheral interrupt request lines and merges them with a register of software-forced requests. Software forces a request by writing ones to a set port. It withdraws a forced request by writing ones to a separate clear port. The merge is a plain bitwise OR, applied ahead of every other stage. The merged vector is readable as raw status, whatever the enable settings are.

A per-source enable mask gates the merged vector. Among the enabled live sources, an arbiter picks the winner with the smallest 4-bit priority number. When two sources have the same priority number, the lower source index wins. The `irq` output is high whenever any enabled source is live.

Each source has a programmable 32-bit vector. The processor claims a source by reading the active-vector location. That read captures the current winner's vector, and the captured value stays put until the processor writes the same location to end service. All register access goes over a simple synchronous bus. Read data is registered and appears on the clock edge that samples the read strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the software-forced register and the enable mask read 0, every priority reads 0xF, every vector reads 0, the active vector reads 0 and `irq` is low.
- R2: Writing offset 0x018 sets each software-forced bit whose data bit is 1 and leaves the bits whose data bit is 0 as they were. Offset 0x018 reads back the software-forced register.
- R3: Writing offset 0x01C clears each software-forced bit whose data bit is 1 and leaves the others as they were. Offset 0x01C always reads 0.
- R4: Offset 0x008 reads the bitwise OR of `hwReq` and the software-forced register, whatever the enable mask holds.
- R5: Writing offset 0x010 sets enable bits where the data bit is 1, and writing offset 0x014 clears enable bits where the data bit is 1. Offset 0x010 reads the enable mask, offset 0x014 reads 0, and offset 0x000 reads the raw status ANDed with the enable mask.
- R6: `irq` is high exactly when at least one source is both requesting and enabled. A source that requests while disabled leaves `irq` low.
- R7: Source n has a 4-bit priority at offset 0x200+4n, held in data bits 3:0. Bits 31:4 of the written data are dropped and read back as 0.
- R8: Source n has a 32-bit vector at offset 0x100+4n, readable and writable.
- R9: The winner is the enabled, requesting source with the smallest priority number. When priority numbers are equal, the lowest source index wins.
- R10: A read of offset 0xF00 while no service is open returns the winner's vector, latches it and opens service; with no enabled request it returns 0 and opens nothing. While service is open, reads return the latched vector even if a better source appears.
- R11: Any write to offset 0xF00 closes service and clears the active vector to 0. The next read of 0xF00 then makes a fresh selection.
- R12: Offsets that are not mapped read 0. Read data is presented on `busRdata` from the clock edge that samples `busRe` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | 32 | Peripheral request lines, active high, synchronous to `clk` |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 12 | Byte offset of the register, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench writes zero bits to the set port and to the clear port. A design that treated those ports as plain stores would wipe or restore forced bits there. The bench also claims a vector, raises a better source while service is open, and re-reads the active vector. A design that tracks the live winner would return a changed vector mid-service. Equal-priority ties are tested. A design that scanned sources downward would return the higher source's vector in that case. The bench also checks raw status against a disabled source. A design that gated raw status with the enable mask would read low there.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  parameter int unsigned SRC_CNT = 32;
  parameter int unsigned PRIO_W  = 4;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned ADDR_W  = 12;
  localparam int unsigned IDX_W  = $clog2(SRC_CNT);

  localparam logic [ADDR_W-1:0] OFF_EN_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_RAW     = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_SW_SET  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_SW_CLR  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_VEC     = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_PRIO    = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_ACTIVE  = 12'hF00;

  typedef enum logic [2:0] {
    RD_NONE, RD_EN_STAT, RD_RAW, RD_EN, RD_SW, RD_VEC, RD_PRIO, RD_ACTIVE
  } rdSel_e;

  typedef struct packed {
    logic             swSet;
    logic             swClr;
    logic             enSet;
    logic             enClr;
    logic             prioWr;
    logic             vecWr;
    logic             claim;
    logic             endSvc;
    logic             rd;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_SRC);

  logic [ADDR_W-1:0] vecOff, prioOff;
  logic              inVec, inPrio, aligned;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign vecOff  = busAddr - OFF_VEC;
  assign prioOff = busAddr - OFF_PRIO;
  assign inVec   = aligned && (busAddr >= OFF_VEC) && (vecOff < SPAN);
  assign inPrio  = aligned && (busAddr >= OFF_PRIO) && (prioOff < SPAN);

  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_NONE;
    stb.rd     = busRe;
    stb.idx    = inVec ? vecOff[IDX_W+1:2] : prioOff[IDX_W+1:2];
    if (busWe) begin
      stb.swSet  = (busAddr == OFF_SW_SET);
      stb.swClr  = (busAddr == OFF_SW_CLR);
      stb.enSet  = (busAddr == OFF_EN_SET);
      stb.enClr  = (busAddr == OFF_EN_CLR);
      stb.vecWr  = inVec;
      stb.prioWr = inPrio;
      stb.endSvc = (busAddr == OFF_ACTIVE);
    end
    if (busRe) begin
      stb.claim = (busAddr == OFF_ACTIVE);
      if      (busAddr == OFF_EN_STAT) stb.rdSel = RD_EN_STAT;
      else if (busAddr == OFF_RAW)     stb.rdSel = RD_RAW;
      else if (busAddr == OFF_EN_SET)  stb.rdSel = RD_EN;
      else if (busAddr == OFF_SW_SET)  stb.rdSel = RD_SW;
      else if (busAddr == OFF_ACTIVE)  stb.rdSel = RD_ACTIVE;
      else if (inVec)                  stb.rdSel = RD_VEC;
      else if (inPrio)                 stb.rdSel = RD_PRIO;
    end
  end
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT
) (
  input  logic [NUM_SRC-1:0]             live,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [IDX_W-1:0]               winIdx
);
  logic [PRIO_W-1:0] bestP;

  // Strict compare while scanning upward keeps the lowest index on a tie.
  always_comb begin
    found  = 1'b0;
    bestP  = '1;
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (live[i] && (!found || prio[i] < bestP)) begin
        found  = 1'b1;
        bestP  = prio[i];
        winIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_dp.sv
module irqv_dp
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq,
  output logic [NUM_SRC-1:0] swBits,
  output logic               inService,
  output logic [DATA_W-1:0]  activeVec
);
  logic [NUM_SRC-1:0]             enMask, raw, live;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab;
  logic [NUM_SRC-1:0][DATA_W-1:0] vecTab;
  logic                           found;
  logic [IDX_W-1:0]               winIdx;
  logic [DATA_W-1:0]              winVec;

  assign raw    = hwReq | swBits;
  assign live   = raw & enMask;
  assign irq    = |live;
  assign winVec = vecTab[winIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swBits <= '0;
      enMask <= '0;
    end else begin
      if (stb.swSet) swBits <= swBits | busWdata[NUM_SRC-1:0];
      if (stb.swClr) swBits <= swBits & ~busWdata[NUM_SRC-1:0];
      if (stb.enSet) enMask <= enMask | busWdata[NUM_SRC-1:0];
      if (stb.enClr) enMask <= enMask & ~busWdata[NUM_SRC-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioTab[g] <= '1;
        vecTab[g]  <= '0;
      end else if (stb.idx == IDX_W'(g)) begin
        if (stb.prioWr) prioTab[g] <= busWdata[PRIO_W-1:0];
        if (stb.vecWr)  vecTab[g]  <= busWdata;
      end
    end
  end

  irqv_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .live   (live),
    .prio   (prioTab),
    .found  (found),
    .winIdx (winIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inService <= 1'b0;
      activeVec <= '0;
    end else if (stb.endSvc) begin
      inService <= 1'b0;
      activeVec <= '0;
    end else if (stb.claim && !inService && found) begin
      inService <= 1'b1;
      activeVec <= winVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rd) begin
      unique case (stb.rdSel)
        RD_EN_STAT: busRdata <= DATA_W'(live);
        RD_RAW:     busRdata <= DATA_W'(raw);
        RD_EN:      busRdata <= DATA_W'(enMask);
        RD_SW:      busRdata <= DATA_W'(swBits);
        RD_VEC:     busRdata <= vecTab[stb.idx];
        RD_PRIO:    busRdata <= DATA_W'(prioTab[stb.idx]);
        RD_ACTIVE:  busRdata <= inService ? activeVec : (found ? winVec : '0);
        default:    busRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq
);
  strobe_t            stb;
  logic [NUM_SRC-1:0] swBits;
  logic               inService;
  logic [DATA_W-1:0]  activeVec;

  irqv_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irqv_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hwReq     (hwReq),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irq       (irq),
    .swBits    (swBits),
    .inService (inService),
    .activeVec (activeVec)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] hwReq,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               irq,
  input logic [NUM_SRC-1:0] swBits,
  input logic               inService,
  input logic [DATA_W-1:0]  activeVec
);
  p_swset_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_SW_SET) |=>
      ((swBits & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  p_swset_zeros_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_SW_SET) |=>
      ((swBits & ~$past(busWdata[NUM_SRC-1:0])) == ($past(swBits) & ~$past(busWdata[NUM_SRC-1:0]))));

  p_swclr_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_SW_CLR) |=>
      ((swBits & $past(busWdata[NUM_SRC-1:0])) == '0));

  p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((hwReq | swBits) != '0));

  p_claim_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !(busWe && busAddr == OFF_ACTIVE)) |=> (inService && $stable(activeVec)));

  p_end_service_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_ACTIVE) |=> (!inService && activeVec == '0));

  p_idle_vector_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inService |-> (activeVec == '0));
endmodule

bind irq_vector_ctrl irqv_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hwReq     (hwReq),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .irq       (irq),
  .swBits    (swBits),
  .inService (inService),
  .activeVec (activeVec)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwReq = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  // Monitor: each sampled read strobe produces one registered result.
  always begin
    @(posedge clk);
    if (busRe) begin
      @(negedge clk);
      if (expQ.size() != 0) begin
        logic [31:0] e;
        string       t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s rdata actual %08h expected %08h", t, busRdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    busRead(12'h018, 32'h0, "R1 sw reg");
    busRead(12'h010, 32'h0, "R1 enable");
    busRead(12'h200, 32'hF, "R1 prio src0");
    busRead(12'h27C, 32'hF, "R1 prio src31");
    busRead(12'h100, 32'h0, "R1 vector src0");
    busRead(12'hF00, 32'h0, "R1 R10 active idle");

    // R2 set semantics, zeros ignored
    busWrite(12'h018, 32'h0000_00F0);
    busRead(12'h018, 32'h0000_00F0, "R2 set ones");
    busWrite(12'h018, 32'h0000_0003);
    busRead(12'h018, 32'h0000_00F3, "R2 zeros keep bits");

    // R3 clear semantics
    busWrite(12'h01C, 32'h0000_0030);
    busRead(12'h018, 32'h0000_00C3, "R3 clear ones");
    busRead(12'h01C, 32'h0, "R3 clear port reads zero");

    // R4 raw status ignores enables; R6 disabled sources keep irq low
    hwReq = 32'h8000_0001;
    busRead(12'h008, 32'h8000_00C3, "R4 raw or");
    checkIrq(1'b0, "R6 nothing enabled");

    // R5 enable set/clear and enabled status
    busWrite(12'h010, 32'h8000_0040);
    busRead(12'h010, 32'h8000_0040, "R5 enable set");
    busRead(12'h000, 32'h8000_0040, "R5 enabled status");
    busWrite(12'h014, 32'h0000_0040);
    busRead(12'h010, 32'h8000_0000, "R5 enable clear");
    busRead(12'h014, 32'h0, "R5 clear port reads zero");
    checkIrq(1'b1, "R6 enabled source");

    // R7 priority width
    busWrite(12'h27C, 32'hFFFF_FFF5);
    busRead(12'h27C, 32'h0000_0005, "R7 prio truncated");

    // R8 vectors
    for (int n = 0; n < 32; n++) busWrite(12'h100 + 12'(4 * n), 32'h1000 + 32'(16 * n));
    busRead(12'h17C, 32'h0000_11F0, "R8 vector src31");
    busRead(12'h104, 32'h0000_1010, "R8 vector src1");

    // R10 claim and hold
    busRead(12'hF00, 32'h0000_11F0, "R10 claim src31");
    busWrite(12'h204, 32'h2);
    busWrite(12'h010, 32'h0000_0002);
    busRead(12'hF00, 32'h0000_11F0, "R10 held during service");

    // R11 end of service then fresh pick; R9 lower value wins
    busWrite(12'hF00, 32'h0);
    busRead(12'hF00, 32'h0000_1010, "R11 R9 reselect src1");

    // R9 tie goes to lower index
    busWrite(12'hF00, 32'h0);
    busWrite(12'h218, 32'h2);
    busWrite(12'h010, 32'h0000_0040);
    busRead(12'hF00, 32'h0000_1010, "R9 tie lowest index");
    busWrite(12'hF00, 32'h0);
    busWrite(12'h218, 32'h1);
    busRead(12'hF00, 32'h0000_1060, "R9 smaller value wins");
    busWrite(12'hF00, 32'h0);

    // R12 unmapped offsets
    busRead(12'h004, 32'h0, "R12 hole 0x004");
    busRead(12'h300, 32'h0, "R12 hole 0x300");
    busRead(12'hF04, 32'h0, "R12 hole 0xF04");

    // R6 all disabled, R10 idle claim returns zero
    busWrite(12'h014, 32'hFFFF_FFFF);
    checkIrq(1'b0, "R6 all disabled");
    busRead(12'hF00, 32'h0, "R10 no request claim");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule